// File: doc/BRIEF.md
# Cache push-and-invalidate sequencer

This block executes a privileged cache maintenance command against a set-associative data cache and a matching instruction cache. A command carries a 16-bit command word (cache choice, scope) together with the physical address already read from the named address register. After a command is accepted, the block walks the tag entries that the scope covers, one way per cycle. Every covered data line that is dirty goes out on a valid/ready write-back port. Every covered line in either cache is then invalidated through the tag port.

The tag and data arrays sit outside the block. It drives the cache/set/way being looked at and receives that entry's valid bit, dirty bit, tag and line data combinationally. It raises an invalidate strobe when that entry must be cleared. A command issued outside supervisor state produces a one-cycle trap pulse and touches nothing. Every other accepted command ends with a one-cycle done pulse. The condition codes are outside this block and are never affected.

Top module: `cache_flush_seq`

## Requirements
- R1: After reset, cmd_ready is 1 and done, trap, wb_valid and tag_inv are 0.
- R2: A command accepted with cmd_super = 0 gives trap = 1 for exactly the next cycle, gives no done, and causes no tag_inv and no write-back.
- R3: The command word is {bits 15..8 = 8'hF4, bits 7..6 = cache select, bit 5 = 1, bits 4..3 = scope, bits 2..0 = register number (not interpreted)}. Cache select 00 = none, 01 = data, 10 = instruction, 11 = both. Scope 01 = line, 10 = page, 11 = all. The command completes with done and no tag_inv and no write-back if any of these holds: the high byte differs from 8'hF4, bit 5 is 0, the scope is 00, or the cache select is 00.
- R4: A covered valid data-cache entry (tag_sel = 0) with its dirty bit set is first written back, with wb_addr = {tag, set, zero offset} and wb_data = its line. It is then invalidated in the cycle after the write-back is accepted. A clean covered data entry is invalidated without a write-back.
- R5: Covered instruction-cache entries (tag_sel = 1) are invalidated only and never written back, even when their dirty input reads 1.
- R6: Line scope covers only the entry whose {tag, set} equals the address bits above the line offset. The offset bits of the address are ignored, and a miss completes with no activity.
- R7: Page scope covers every valid entry whose line address lies in the same PAGE_BYTES page (4 KiB by default) as the supplied address.
- R8: All scope covers every valid entry of each selected cache, whatever the address.
- R9: Work proceeds through the data cache before the instruction cache, sets ascending, ways ascending within a set.
- R10: While wb_valid = 1 and wb_ready = 0, wb_valid stays 1 and wb_addr and wb_data stay unchanged.
- R11: done is a single-cycle pulse. It comes one cycle after the invalidate of the last walked entry when that entry was invalidated. cmd_ready is 0 from acceptance until after done or trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and accepting a command |
| cmd_word | input | 16 | Command word |
| cmd_addr | input | ADDR_W | Physical address from the named address register |
| cmd_super | input | 1 | Issuer is in supervisor state |
| trap | output | 1 | Privilege trap pulse |
| done | output | 1 | Command completion pulse |
| tag_sel | output | 1 | Cache being looked at: 0 data, 1 instruction |
| tag_set | output | IDX_W | Set being looked at |
| tag_way | output | WAY_W | Way being looked at |
| tag_valid_in | input | 1 | Valid bit of the addressed entry |
| tag_dirty_in | input | 1 | Dirty bit of the addressed entry |
| tag_in | input | TAG_W | Tag of the addressed entry |
| data_line_in | input | LINE_W | Data-cache line of the addressed entry |
| tag_inv | output | 1 | Clear valid and dirty of the addressed entry at this edge |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | ADDR_W | Write-back line address |
| wb_data | output | LINE_W | Write-back line data |

## Verification
The hardest case to reach is a page-scope command over both caches that hits several dirty data lines while the memory port stalls at random. In that case the held write-back registers, the delayed invalidate and the walk order all interact. The bench fills its own behavioural arrays with lines inside and outside one 4 KiB page, including lines in the top set and last way, and drives wb_ready from a random pattern. Each write-back and invalidate is compared, in order, with an event queue derived from the array contents. A last-entry hit under all scope pins down the done timing.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DATA = 2'b01,
    SEL_INST = 2'b10,
    SEL_BOTH = 2'b11
  } csel_e;

  typedef enum logic [1:0] {
    SCP_BAD  = 2'b00,
    SCP_LINE = 2'b01,
    SCP_PAGE = 2'b10,
    SCP_ALL  = 2'b11
  } scope_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WB,
    ST_INV,
    ST_DONE,
    ST_TRAP
  } state_e;

  localparam logic [7:0] OPC_HI = 8'hF4;

  typedef struct packed {
    csel_e  sel;
    scope_e scope;
    logic   legal;
    logic   noop;
  } cmd_t;
endpackage

// File: rtl/cfs_decode.sv
module cfs_decode
  import cfs_pkg::*;
(
  input  logic [15:0] word,
  output cmd_t        cmd
);
  // Major opcode byte and push/invalidate bit must both be present.
  function automatic logic opcode_ok(input logic [15:0] w);
    return (w[15:8] == OPC_HI) && w[5];
  endfunction

  function automatic logic scope_ok(input logic [1:0] s);
    return s != 2'b00;
  endfunction

  // Register number is resolved before the block; only folded away here.
  logic unused_regnum;
  assign unused_regnum = ^word[2:0];

  always_comb begin
    cmd.sel   = csel_e'(word[7:6]);
    cmd.scope = scope_e'(word[4:3]);
    cmd.legal = opcode_ok(word) && scope_ok(word[4:3]);
    cmd.noop  = !cmd.legal || (word[7:6] == 2'b00);
  end
endmodule

// File: rtl/cfs_walker.sv
module cfs_walker
  import cfs_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int OFF_W  = 4,
  parameter  int IDX_W  = 6,
  parameter  int WAYS   = 2,
  parameter  int WAY_W  = 1,
  parameter  int PAGE_W = 12,
  localparam int LN_W   = ADDR_W - OFF_W,
  localparam int TAG_W  = LN_W - IDX_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  csel_e            sel,
  input  scope_e           scope,
  input  logic [LN_W-1:0]  lnum,
  input  logic             tag_valid,
  input  logic [TAG_W-1:0] tag,
  output logic             cur_inst,
  output logic [IDX_W-1:0] cur_set,
  output logic [WAY_W-1:0] cur_way,
  output logic             last,
  output logic             hit
);
  localparam int SPAN_W   = PAGE_W - OFF_W;
  localparam int PG_IDX_W = (SPAN_W < IDX_W) ? SPAN_W : IDX_W;
  localparam logic [IDX_W-1:0] PG_MASK  = IDX_W'((64'd1 << PG_IDX_W) - 64'd1);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  function automatic logic [IDX_W-1:0] index_of(input logic [LN_W-1:0] l);
    return l[IDX_W-1:0];
  endfunction

  // First set the scope can cover.
  function automatic logic [IDX_W-1:0] range_lo(input scope_e s, input logic [LN_W-1:0] l);
    case (s)
      SCP_LINE: return index_of(l);
      SCP_PAGE: return index_of(l) & ~PG_MASK;
      default:  return '0;
    endcase
  endfunction

  // Last set the scope can cover.
  function automatic logic [IDX_W-1:0] range_hi(input scope_e s, input logic [LN_W-1:0] l);
    case (s)
      SCP_LINE: return index_of(l);
      SCP_PAGE: return index_of(l) | PG_MASK;
      default:  return '1;
    endcase
  endfunction

  // Whether an entry's line number falls under the scope.
  function automatic logic line_hits(input scope_e s, input logic [TAG_W-1:0] t,
                                     input logic [IDX_W-1:0] i, input logic [LN_W-1:0] want);
    logic [LN_W-1:0] have;
    have = {t, i};
    case (s)
      SCP_LINE: return have == want;
      SCP_PAGE: return (have >> SPAN_W) == (want >> SPAN_W);
      SCP_ALL:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  scope_e           scope_q;
  logic [LN_W-1:0]  want_q;
  logic             both_q;
  logic [IDX_W-1:0] lo_q, hi_q, set_q;
  logic [WAY_W-1:0] way_q;
  logic             inst_q;
  logic             way_wrap, set_wrap;

  assign way_wrap = (way_q == LAST_WAY);
  assign set_wrap = (set_q == hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scope_q <= SCP_BAD;
      want_q  <= '0;
      both_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      set_q   <= '0;
      way_q   <= '0;
      inst_q  <= 1'b0;
    end else if (load) begin
      scope_q <= scope;
      want_q  <= lnum;
      both_q  <= (sel == SEL_BOTH);
      inst_q  <= (sel == SEL_INST);
      lo_q    <= range_lo(scope, lnum);
      hi_q    <= range_hi(scope, lnum);
      set_q   <= range_lo(scope, lnum);
      way_q   <= '0;
    end else if (step) begin
      if (way_wrap) begin
        way_q <= '0;
        if (set_wrap) begin
          inst_q <= 1'b1;
          set_q  <= lo_q;
        end else begin
          set_q <= set_q + 1'b1;
        end
      end else begin
        way_q <= way_q + 1'b1;
      end
    end
  end

  assign cur_inst = inst_q;
  assign cur_set  = set_q;
  assign cur_way  = way_q;
  assign last     = way_wrap && set_wrap && (inst_q || !both_q);
  assign hit      = tag_valid && line_hits(scope_q, tag, set_q, want_q);

  // R6: the walk never leaves the set range chosen at load.
  assert_set_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q >= lo_q) && (set_q <= hi_q));

  // R9: the instruction cache is never left once entered, until a new load.
  assert_data_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_q && !load) |=> inst_q);
endmodule

// File: rtl/cfs_writeback.sv
module cfs_writeback #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              pending,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic [LINE_W-1:0] line_data,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data,
  output logic              wb_fire
);
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= line_addr;
      data_q <= line_data;
    end
  end

  assign wb_valid = pending;
  assign wb_addr  = addr_q;
  assign wb_data  = data_q;
  assign wb_fire  = pending && wb_ready;

  assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq
  import cfs_pkg::*;
#(
  parameter  int ADDR_W     = 32,
  parameter  int LINE_BYTES = 16,
  parameter  int SETS       = 64,
  parameter  int WAYS       = 2,
  parameter  int PAGE_BYTES = 4096,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(SETS),
  localparam int WAY_W      = $clog2(WAYS),
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W,
  localparam int PAGE_W     = $clog2(PAGE_BYTES),
  localparam int LINE_W     = LINE_BYTES * 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_word,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_super,
  output logic              trap,
  output logic              done,
  output logic              tag_sel,
  output logic [IDX_W-1:0]  tag_set,
  output logic [WAY_W-1:0]  tag_way,
  input  logic              tag_valid_in,
  input  logic              tag_dirty_in,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [LINE_W-1:0] data_line_in,
  output logic              tag_inv,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  state_e state, state_nx;
  cmd_t   dec;

  logic accept, walk_load, walk_step, hit, last, cur_inst, need_wb, wb_fire;
  logic [IDX_W-1:0] cur_set;
  logic [WAY_W-1:0] cur_way;
  logic [ADDR_W-1:0] line_addr;

  logic unused_offset;
  assign unused_offset = ^cmd_addr[OFF_W-1:0];

  cfs_decode u_decode (.word(cmd_word), .cmd(dec));

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign walk_load = accept && cmd_super && !dec.noop;

  cfs_walker #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .WAYS(WAYS), .WAY_W(WAY_W), .PAGE_W(PAGE_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_n), .load(walk_load), .step(walk_step),
    .sel(dec.sel), .scope(dec.scope), .lnum(cmd_addr[ADDR_W-1:OFF_W]),
    .tag_valid(tag_valid_in), .tag(tag_in),
    .cur_inst(cur_inst), .cur_set(cur_set), .cur_way(cur_way),
    .last(last), .hit(hit)
  );

  // Only data-cache entries can carry dirty data worth pushing.
  assign need_wb   = hit && !cur_inst && tag_dirty_in;
  assign line_addr = {tag_in, cur_set, {OFF_W{1'b0}}};

  cfs_writeback #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .capture((state == ST_SCAN) && need_wb),
    .pending(state == ST_WB),
    .line_addr(line_addr), .line_data(data_line_in),
    .wb_ready(wb_ready), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_fire(wb_fire)
  );

  assign walk_step = ((state == ST_SCAN) && !need_wb && !last) ||
                     ((state == ST_INV) && !last);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (accept) begin
        if (!cmd_super)    state_nx = ST_TRAP;
        else if (dec.noop) state_nx = ST_DONE;
        else               state_nx = ST_SCAN;
      end
      ST_SCAN: if (need_wb) state_nx = ST_WB;
               else if (last) state_nx = ST_DONE;
      ST_WB:   if (wb_fire) state_nx = ST_INV;
      ST_INV:  state_nx = last ? ST_DONE : ST_SCAN;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign tag_sel = cur_inst;
  assign tag_set = cur_set;
  assign tag_way = cur_way;
  assign tag_inv = ((state == ST_SCAN) && hit && !need_wb) || (state == ST_INV);
  assign done    = (state == ST_DONE);
  assign trap    = (state == ST_TRAP);

  assert_trap_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_super) |=> (trap && !tag_inv && !wb_valid && !done));

  assert_noop_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_super && dec.noop) |=> (done && !tag_inv));

  assert_inv_after_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INV) |-> $past(wb_fire));

  assert_inst_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !cur_inst);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
endmodule

// File: tb/test_cache_flush_seq.sv
module test_cache_flush_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, LINE_BYTES = 16, SETS = 64, WAYS = 2, PAGE_BYTES = 4096;
  localparam int OFF_W = $clog2(LINE_BYTES), IDX_W = $clog2(SETS), WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W, PAGE_W = $clog2(PAGE_BYTES);
  localparam int LINE_W = LINE_BYTES * 8;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_super = 0, wb_ready = 1;
  logic [15:0] cmd_word = 0;
  logic [ADDR_W-1:0] cmd_addr = 0;
  logic cmd_ready, trap, done, tag_sel, tag_valid_in, tag_dirty_in, tag_inv, wb_valid;
  logic [IDX_W-1:0] tag_set;
  logic [WAY_W-1:0] tag_way;
  logic [TAG_W-1:0] tag_in;
  logic [LINE_W-1:0] data_line_in, wb_data;
  logic [ADDR_W-1:0] wb_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_flush_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS),
                    .WAYS(WAYS), .PAGE_BYTES(PAGE_BYTES)) i_cache_flush_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_addr(cmd_addr), .cmd_super(cmd_super),
    .trap(trap), .done(done), .tag_sel(tag_sel), .tag_set(tag_set), .tag_way(tag_way),
    .tag_valid_in(tag_valid_in), .tag_dirty_in(tag_dirty_in), .tag_in(tag_in),
    .data_line_in(data_line_in), .tag_inv(tag_inv), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data));

  // Behavioural cache arrays: index 0 = data cache, 1 = instruction cache.
  logic             bv  [0:1][0:SETS-1][0:WAYS-1];
  logic             bd  [0:1][0:SETS-1][0:WAYS-1];
  logic [TAG_W-1:0] bt  [0:1][0:SETS-1][0:WAYS-1];
  logic [LINE_W-1:0] bl [0:SETS-1][0:WAYS-1];

  always_comb begin
    tag_valid_in = bv[tag_sel][tag_set][tag_way];
    tag_dirty_in = bd[tag_sel][tag_set][tag_way];
    tag_in       = bt[tag_sel][tag_set][tag_way];
    data_line_in = bl[tag_set][tag_way];
  end

  typedef struct packed {
    logic              is_inv;
    logic              c;
    logic [IDX_W-1:0]  s;
    logic [WAY_W-1:0]  w;
    logic [ADDR_W-1:0] a;
    logic [LINE_W-1:0] d;
  } ev_t;
  ev_t q[$];

  int checks = 0, errors = 0, cyc = 0, last_inv_cyc = -10, inv_cnt = 0, wb_cnt = 0;
  bit exp_last_hit = 0, stall_mode = 0, held = 0, finished = 0;
  logic [ADDR_W-1:0] held_a;
  logic [LINE_W-1:0] held_d;

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  endtask

  always @(negedge clk) wb_ready <= stall_mode ? ($urandom_range(0, 2) == 0) : 1'b1;

  // Per-clock comparison of the port activity against the expected event queue.
  always @(posedge clk) begin
    if (rst_n) begin
      if (held) chk(wb_valid && wb_addr == held_a && wb_data == held_d, "R10 hold",
                    {wb_addr, wb_data}, {held_a, held_d});
      held = wb_valid && !wb_ready;
      held_a = wb_addr; held_d = wb_data;
      if (wb_valid && wb_ready) begin
        wb_cnt++;
        if (q.size() == 0 || q[0].is_inv)
          chk(0, "R4 unexpected write-back", {wb_addr, wb_data}, 0);
        else begin
          chk({wb_addr, wb_data} == {q[0].a, q[0].d}, "R4 write-back",
              {wb_addr, wb_data}, {q[0].a, q[0].d});
          void'(q.pop_front());
        end
      end
      if (tag_inv) begin
        inv_cnt++;
        last_inv_cyc = cyc;
        if (q.size() == 0 || !q[0].is_inv)
          chk(0, "R9 unexpected invalidate", {tag_sel, tag_set, tag_way}, 0);
        else begin
          chk({tag_sel, tag_set, tag_way} == {q[0].c, q[0].s, q[0].w}, "R9 invalidate order",
              {tag_sel, tag_set, tag_way}, {q[0].c, q[0].s, q[0].w});
          void'(q.pop_front());
        end
        bv[tag_sel][tag_set][tag_way] <= 1'b0;
        bd[tag_sel][tag_set][tag_way] <= 1'b0;
      end
      if (done && exp_last_hit)
        chk(cyc == last_inv_cyc + 1, "R11 done after last invalidate", cyc, last_inv_cyc + 1);
    end
    cyc++;
  end

  task automatic clear_all();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          bv[c][s][w] <= 0; bd[c][s][w] <= 0; bt[c][s][w] <= '0;
          if (c == 0) bl[s][w] <= {4{32'hD000_0000 + 32'(s * 16 + w)}};
        end
  endtask

  task automatic fill(input int c, input int s, input int w, input logic [TAG_W-1:0] t, input bit dirty);
    bv[c][s][w] <= 1; bd[c][s][w] <= dirty; bt[c][s][w] <= t;
  endtask

  // Page 0x12345000 holds tags 0x48D14..0x48D17.
  task automatic populate();
    @(negedge clk);
    clear_all();
    fill(0, 5, 0, 22'h00ABC, 1);  fill(0, 5, 1, 22'h48D14, 1);
    fill(0, 9, 0, 22'h48D15, 0);  fill(0, 20, 1, 22'h48D17, 1);
    fill(0, 33, 0, 22'h3FFFF, 1); fill(0, 63, 1, 22'h48D16, 1);
    fill(1, 5, 0, 22'h48D14, 1);  fill(1, 12, 1, 22'h00ABC, 0);
    fill(1, 40, 0, 22'h48D16, 0); fill(1, 63, 1, 22'h12345, 0);
    @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [1:0] sel, input logic [1:0] scp, input logic [2:0] rn);
    return {8'hF4, sel, 1'b1, scp, rn};
  endfunction

  task automatic build_expect(input logic [1:0] sel, input logic [1:0] scp, input logic [ADDR_W-1:0] addr);
    int lpp, ls, lc;
    ev_t e;
    lpp = 1 << (PAGE_W - OFF_W);
    for (int c = 0; c < 2; c++) begin
      if (!sel[c]) continue;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          logic [ADDR_W-1:0] la;
          bit m;
          la = {bt[c][s][w], IDX_W'(s), {OFF_W{1'b0}}};
          if (scp == 2'b01)      m = (la >> OFF_W) == (addr >> OFF_W);
          else if (scp == 2'b10) m = (la >> PAGE_W) == (addr >> PAGE_W);
          else                   m = 1;
          if (bv[c][s][w] && m) begin
            e = '0; e.c = c[0]; e.s = IDX_W'(s); e.w = WAY_W'(w);
            if (c == 0 && bd[c][s][w]) begin
              e.is_inv = 0; e.a = la; e.d = bl[s][w]; q.push_back(e);
            end
            e.is_inv = 1; e.a = '0; e.d = '0; q.push_back(e);
          end
        end
    end
    lc = sel[1] ? 1 : 0;
    if (scp == 2'b01) ls = int'((addr >> OFF_W) % SETS);
    else if (scp == 2'b10 && lpp < SETS) ls = int'((addr >> OFF_W) % SETS) | (lpp - 1);
    else ls = SETS - 1;
    exp_last_hit = q.size() > 0 && q[$].is_inv && q[$].c == lc[0] &&
                   q[$].s == IDX_W'(ls) && q[$].w == WAY_W'(WAYS - 1);
  endtask

  task automatic run_cmd(input logic [15:0] word, input logic [ADDR_W-1:0] addr, input bit sup, input string req);
    bit legal, exp_trap;
    int n;
    legal = (word[15:8] == 8'hF4) && word[5] && (word[4:3] != 2'b00);
    q.delete(); exp_last_hit = 0; inv_cnt = 0; wb_cnt = 0;
    if (sup && legal && word[7:6] != 2'b00) build_expect(word[7:6], word[4:3], addr);
    exp_trap = !sup;
    @(negedge clk);
    chk(cmd_ready, {req, " ready before command"}, cmd_ready, 1);
    cmd_valid = 1; cmd_word = word; cmd_addr = addr; cmd_super = sup;
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R11 busy after accept", cmd_ready, 0);
    n = 0;
    while (!(done || trap) && n < 20000) begin @(negedge clk); n++; end
    chk(trap == exp_trap, {req, " trap"}, trap, exp_trap);
    chk(done == !exp_trap, {req, " done"}, done, !exp_trap);
    chk(q.size() == 0, {req, " events outstanding"}, q.size(), 0);
    @(negedge clk);
    chk(!done && !trap, "R11 single-cycle pulse", {done, trap}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready && !done && !trap && !wb_valid && !tag_inv, "R1 reset state",
        {cmd_ready, done, trap, wb_valid, tag_inv}, 5'b10000);
    rst_n = 1;

    populate();
    run_cmd(mk(2'b11, 2'b11, 3'd0), 32'h0, 0, "R2 user-state trap");
    chk(inv_cnt == 0 && wb_cnt == 0, "R2 no cache activity", {inv_cnt, wb_cnt}, 0);

    run_cmd({8'hF4, 2'b11, 1'b1, 2'b00, 3'd1}, 32'h0, 1, "R3 scope 00");
    run_cmd({8'hF4, 2'b11, 1'b0, 2'b11, 3'd2}, 32'h0, 1, "R3 bit5 clear");
    run_cmd({8'hF5, 2'b11, 1'b1, 2'b11, 3'd3}, 32'h0, 1, "R3 wrong opcode");
    run_cmd(mk(2'b00, 2'b11, 3'd4), 32'h0, 1, "R3 no cache");
    chk(inv_cnt == 0 && wb_cnt == 0, "R3 no cache activity", {inv_cnt, wb_cnt}, 0);

    run_cmd(mk(2'b01, 2'b01, 3'd5), 32'h1234505C, 1, "R6 line dirty data");
    chk(wb_cnt == 1 && inv_cnt == 1, "R4 line push then invalidate", {wb_cnt, inv_cnt}, {32'd1, 32'd1});
    run_cmd(mk(2'b10, 2'b01, 3'd6), 32'h12345050, 1, "R5 line instruction");
    chk(wb_cnt == 0 && inv_cnt == 1, "R5 instruction invalidate only", {wb_cnt, inv_cnt}, {32'd0, 32'd1});
    run_cmd(mk(2'b11, 2'b01, 3'd7), 32'h12345060, 1, "R6 line miss");
    chk(wb_cnt == 0 && inv_cnt == 0, "R6 miss untouched", {wb_cnt, inv_cnt}, 0);

    populate();
    stall_mode = 1;
    run_cmd(mk(2'b11, 2'b10, 3'd0), 32'h12345ABC, 1, "R7 page both stalled");
    chk(wb_cnt == 3 && inv_cnt == 6, "R7 page coverage", {wb_cnt, inv_cnt}, {32'd3, 32'd6});
    stall_mode = 0;

    populate();
    run_cmd(mk(2'b01, 2'b11, 3'd1), 32'hFFFF_FFF0, 1, "R8 all data");
    chk(wb_cnt == 5 && inv_cnt == 6, "R8 all data coverage", {wb_cnt, inv_cnt}, {32'd5, 32'd6});
    populate();
    stall_mode = 1;
    run_cmd(mk(2'b11, 2'b11, 3'd2), 32'h0, 1, "R9 all both");
    chk(wb_cnt == 5 && inv_cnt == 10, "R8 all both coverage", {wb_cnt, inv_cnt}, {32'd5, 32'd10});
    stall_mode = 0;
    summary();
  end
endmodule